// File: doc/BRIEF.md
# Multi-Port Shared Memory with Access Conflict Resolution

This block is a small shared word store that several processor ports use in lockstep. In every cycle each port may issue one request: a read or a write, with an address and, for a write, a data word. The cycle has two phases. All reads sample the store first. All writes that are allowed then commit together at the clock edge. The response of a read arrives one cycle later.

The block compares the addresses of all ports in the same cycle and applies a selectable access discipline. Reads can be exclusive or shared. Writes can be exclusive or concurrent. A request that breaks an exclusive discipline raises the error flag of its port, and its access is dropped. When concurrent writes are allowed, a policy input decides how colliding values to one word are resolved. The policies are: equal-values-only, keep-the-lowest-port, minimum, wrapping sum, and maximum. Collisions on one word never affect requests to other words in the same cycle.

Top module: `shmem_resolver`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rspValid` and `errFlag` are all zero. Every word of the store reads as zero after reset.
- R2: A read that is granted returns `rspValid`=1 and the stored word on its `rspRData` slice one cycle after the request. The word is the value held before that cycle's writes. A port that has no granted read drives its `rspRData` slice to zero.
- R3: With `readConcurrent`=0, when two or more ports read the same address in one cycle, every one of those readers gets `errFlag`=1, `rspValid`=0 and data zero in the next cycle.
- R4: With `readConcurrent`=1, any number of ports may read the same address in one cycle. Each of them receives the stored word with no error.
- R5: With `writeConcurrent`=0, when two or more ports write one address in one cycle, every one of those writers is flagged and the word keeps its old value. Writes to other addresses in that cycle still commit.
- R6: With `writeConcurrent`=1 and `writePolicy`=0 (equal-only), colliding writers that all supply the same value store that value. If any value differs, all of those writers are flagged and the word is unchanged.
- R7: With `writeConcurrent`=1 and `writePolicy`=1 (keep-lowest), the value from the lowest-numbered colliding port is stored and no error is raised. Codes 5 to 7 behave the same way.
- R8: With `writeConcurrent`=1 and `writePolicy`=2, the smallest colliding value, compared as unsigned, is stored.
- R9: With `writeConcurrent`=1 and `writePolicy`=3, the sum of the colliding values modulo 2^DATA_W is stored.
- R10: With `writeConcurrent`=1 and `writePolicy`=4, the largest colliding value, compared as unsigned, is stored.
- R11: A port whose `reqValid` is 0 gets `errFlag`=0 and `rspValid`=0 in the next cycle. A lone write commits its data, and a later read sees it.
- R12: A read and a write to the same address in the same cycle never conflict. Neither request is flagged, and the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readConcurrent | input | 1 | 1: shared reads allowed; 0: exclusive reads |
| writeConcurrent | input | 1 | 1: concurrent writes resolved by policy; 0: exclusive writes |
| writePolicy | input | 3 | Concurrent-write policy: 0 equal-only, 1 keep-lowest, 2 min, 3 sum, 4 max, 5-7 keep-lowest |
| reqValid | input | PORTS | Per-port request present |
| reqWrite | input | PORTS | Per-port 1 = write, 0 = read |
| reqAddr | input | PORTS*ADDR_W | Per-port word address, port p at bits [p*ADDR_W +: ADDR_W] |
| reqWData | input | PORTS*DATA_W | Per-port write data, port p at bits [p*DATA_W +: DATA_W] |
| rspValid | output | PORTS | Per-port read response valid, one cycle after the request |
| rspRData | output | PORTS*DATA_W | Per-port read data, port p at bits [p*DATA_W +: DATA_W] |
| errFlag | output | PORTS | Per-port conflict flag for the previous cycle's request |

## Verification
The bench uses the default build of four ports, eight words and 8-bit data. Four ports allow a three-way collision next to an unrelated fourth request in the same cycle, so the bench can show that errors and merges stay on one address. Eight words leave room for each policy case to use its own address. The 8-bit width lets the sum policy wrap past 255 in a single collision. A behavioural reference model checks every port on every clock.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  // Sizing of the shared store and its port set.
  localparam int PORTS  = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int WORDS  = 1 << ADDR_W;

  // How the datapath folds several granted writes to one word.
  typedef enum logic [1:0] {
    MRG_LOWEST = 2'd0,
    MRG_MIN    = 2'd1,
    MRG_SUM    = 2'd2,
    MRG_MAX    = 2'd3
  } mergeOp_e;

  // Strobes from the conflict control to the storage datapath.
  typedef struct packed {
    logic [PORTS-1:0] readOk;
    logic [PORTS-1:0] writeOk;
    mergeOp_e         mergeOp;
  } strobe_t;
endpackage

// File: rtl/shmem_conflict_ctrl.sv
module shmem_conflict_ctrl
  import shmem_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     readConcurrent,
  input  logic                     writeConcurrent,
  input  logic [2:0]               writePolicy,
  input  logic [PORTS-1:0]         reqValid,
  input  logic [PORTS-1:0]         reqWrite,
  input  logic [PORTS*ADDR_W-1:0]  reqAddr,
  input  logic [PORTS*DATA_W-1:0]  reqWData,
  output strobe_t                  strobes,
  output logic [PORTS-1:0]         errFlag
);
  logic [PORTS-1:0] readColl, writeColl, valueMismatch;
  logic [PORTS-1:0] readErr, writeErr;
  logic             commonPolicy;

  assign commonPolicy = (writePolicy == 3'd0);

  // Pairwise address compare across all ports.
  always_comb begin
    readColl      = '0;
    writeColl     = '0;
    valueMismatch = '0;
    for (int p = 0; p < PORTS; p++) begin
      for (int q = 0; q < PORTS; q++) begin
        if (q != p && reqValid[q] &&
            reqAddr[q*ADDR_W +: ADDR_W] == reqAddr[p*ADDR_W +: ADDR_W]) begin
          if (!reqWrite[q]) begin
            readColl[p] = 1'b1;
          end else begin
            writeColl[p] = 1'b1;
            if (reqWData[q*DATA_W +: DATA_W] != reqWData[p*DATA_W +: DATA_W])
              valueMismatch[p] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      readErr[p]  = reqValid[p] && !reqWrite[p] && !readConcurrent && readColl[p];
      writeErr[p] = reqValid[p] && reqWrite[p] &&
                    ((!writeConcurrent && writeColl[p]) ||
                     (writeConcurrent && commonPolicy && valueMismatch[p]));
    end
  end

  always_comb begin
    strobes.readOk  = reqValid & ~reqWrite & ~readErr;
    strobes.writeOk = reqValid & reqWrite & ~writeErr;
    strobes.mergeOp = MRG_LOWEST;
    if (writeConcurrent) begin
      case (writePolicy)
        3'd2:    strobes.mergeOp = MRG_MIN;
        3'd3:    strobes.mergeOp = MRG_SUM;
        3'd4:    strobes.mergeOp = MRG_MAX;
        default: strobes.mergeOp = MRG_LOWEST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= '0;
    else       errFlag <= readErr | writeErr;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_portChk
    // R11
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[p] |=> !errFlag[p]);
    for (genvar q = p + 1; q < PORTS; q++) begin : g_pairChk
      // R3
      excl_read_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[p] && reqValid[q] && !reqWrite[p] && !reqWrite[q] && !readConcurrent &&
         reqAddr[p*ADDR_W +: ADDR_W] == reqAddr[q*ADDR_W +: ADDR_W])
        |=> (errFlag[p] && errFlag[q]));
      // R5
      excl_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[p] && reqValid[q] && reqWrite[p] && reqWrite[q] && !writeConcurrent &&
         reqAddr[p*ADDR_W +: ADDR_W] == reqAddr[q*ADDR_W +: ADDR_W])
        |=> (errFlag[p] && errFlag[q]));
    end
  end
endmodule

// File: rtl/shmem_store_dp.sv
module shmem_store_dp
  import shmem_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  logic [PORTS*ADDR_W-1:0]  reqAddr,
  input  logic [PORTS*DATA_W-1:0]  reqWData,
  output logic [PORTS-1:0]         rspValid,
  output logic [PORTS*DATA_W-1:0]  rspRData
);
  logic [DATA_W-1:0] memWord  [WORDS];
  logic [DATA_W-1:0] wordNext [WORDS];
  logic [WORDS-1:0]  wordHit;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    // Fold every granted write aimed at this word, in ascending port order.
    always_comb begin
      wordHit[w]  = 1'b0;
      wordNext[w] = memWord[w];
      for (int p = 0; p < PORTS; p++) begin
        if (strobes.writeOk[p] && reqAddr[p*ADDR_W +: ADDR_W] == ADDR_W'(w)) begin
          if (!wordHit[w]) begin
            wordNext[w] = reqWData[p*DATA_W +: DATA_W];
          end else begin
            case (strobes.mergeOp)
              MRG_MIN: if (reqWData[p*DATA_W +: DATA_W] < wordNext[w])
                         wordNext[w] = reqWData[p*DATA_W +: DATA_W];
              MRG_MAX: if (reqWData[p*DATA_W +: DATA_W] > wordNext[w])
                         wordNext[w] = reqWData[p*DATA_W +: DATA_W];
              MRG_SUM: wordNext[w] = wordNext[w] + reqWData[p*DATA_W +: DATA_W];
              default: wordNext[w] = wordNext[w];
            endcase
          end
          wordHit[w] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)           memWord[w] <= '0;
      else if (wordHit[w]) memWord[w] <= wordNext[w];
    end

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !wordHit[w] |=> $stable(memWord[w]));
  end

  // Read phase samples the store before this cycle's writes land.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= '0;
      rspRData <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        rspValid[p] <= strobes.readOk[p];
        rspRData[p*DATA_W +: DATA_W] <= strobes.readOk[p] ?
          memWord[reqAddr[p*ADDR_W +: ADDR_W]] : '0;
      end
    end
  end
endmodule

// File: rtl/shmem_resolver.sv
module shmem_resolver
  import shmem_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     readConcurrent,
  input  logic                     writeConcurrent,
  input  logic [2:0]               writePolicy,
  input  logic [PORTS-1:0]         reqValid,
  input  logic [PORTS-1:0]         reqWrite,
  input  logic [PORTS*ADDR_W-1:0]  reqAddr,
  input  logic [PORTS*DATA_W-1:0]  reqWData,
  output logic [PORTS-1:0]         rspValid,
  output logic [PORTS*DATA_W-1:0]  rspRData,
  output logic [PORTS-1:0]         errFlag
);
  strobe_t strobes;

  shmem_conflict_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .readConcurrent(readConcurrent), .writeConcurrent(writeConcurrent),
    .writePolicy(writePolicy),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData),
    .strobes(strobes), .errFlag(errFlag)
  );

  shmem_store_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqWData(reqWData),
    .rspValid(rspValid), .rspRData(rspRData)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_topChk
    // R4
    conc_read_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && !reqWrite[p] && readConcurrent) |=> (rspValid[p] && !errFlag[p]));
    // R2
    resp_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(rspValid[p] && errFlag[p]));
    // R11
    idle_no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[p] |=> !rspValid[p]);
  end
endmodule

// File: tb/shmem_resolver_tb_top.sv
module shmem_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NW = 8;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readConcurrent = 1'b0, writeConcurrent = 1'b0;
  logic [2:0] writePolicy = 3'd0;
  logic [NP-1:0] reqValid = '0, reqWrite = '0;
  logic [NP*AW-1:0] reqAddr = '0;
  logic [NP*DW-1:0] reqWData = '0;
  logic [NP-1:0] rspValid, errFlag;
  logic [NP*DW-1:0] rspRData;

  int checks = 0;
  int failures = 0;
  int refMem [NW];
  bit vld [NP];
  bit wr  [NP];
  int adr [NP];
  int dat [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  shmem_resolver dut_i (
    .clk(clk), .rstN(rstN),
    .readConcurrent(readConcurrent), .writeConcurrent(writeConcurrent),
    .writePolicy(writePolicy),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .rspValid(rspValid), .rspRData(rspRData), .errFlag(errFlag)
  );

  task automatic clearReq();
    for (int p = 0; p < NP; p++) begin
      vld[p] = 0; wr[p] = 0; adr[p] = 0; dat[p] = 0;
    end
  endtask

  task automatic setReq(int p, bit isWr, int a, int d);
    vld[p] = 1; wr[p] = isWr; adr[p] = a; dat[p] = d;
  endtask

  task automatic checkPort(string tag, int p, bit v, int d, bit e);
    checks++;
    if (rspValid[p] !== v || int'(rspRData[p*DW +: DW]) != d || errFlag[p] !== e) begin
      failures++;
      $display("FAIL %s port %0d: got valid=%0b data=%0h err=%0b, expected valid=%0b data=%0h err=%0b",
               tag, p, rspValid[p], rspRData[p*DW +: DW], errFlag[p], v, d, e);
    end
  endtask

  // Drive one cycle of requests, advance the model, check after the edge.
  task automatic stepCycle(string tag);
    bit expV [NP];
    int expD [NP];
    bit expE [NP];
    int nextMem [NW];
    for (int p = 0; p < NP; p++) begin
      reqValid[p] = vld[p];
      reqWrite[p] = wr[p];
      reqAddr[p*AW +: AW] = AW'(adr[p]);
      reqWData[p*DW +: DW] = DW'(dat[p]);
      expV[p] = 0; expD[p] = 0; expE[p] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      if (vld[p] && !wr[p]) begin
        int others = 0;
        for (int q = 0; q < NP; q++)
          if (q != p && vld[q] && !wr[q] && adr[q] == adr[p]) others++;
        if (!readConcurrent && others > 0) expE[p] = 1;
        else begin expV[p] = 1; expD[p] = refMem[adr[p]]; end
      end
    end
    for (int a = 0; a < NW; a++) nextMem[a] = refMem[a];
    for (int a = 0; a < NW; a++) begin
      int hits[$];
      int val;
      bit bad = 0;
      for (int p = 0; p < NP; p++) if (vld[p] && wr[p] && adr[p] == a) hits.push_back(p);
      if (hits.size() == 0) continue;
      if (hits.size() > 1 && !writeConcurrent) bad = 1;
      if (hits.size() > 1 && writeConcurrent && writePolicy == 3'd0)
        foreach (hits[i]) if (dat[hits[i]] != dat[hits[0]]) bad = 1;
      if (bad) begin
        foreach (hits[i]) expE[hits[i]] = 1;
        continue;
      end
      val = dat[hits[0]];
      if (writeConcurrent) begin
        foreach (hits[i]) begin
          if (i == 0) continue;
          case (writePolicy)
            3'd2: if (dat[hits[i]] < val) val = dat[hits[i]];
            3'd3: val = (val + dat[hits[i]]) % 256;
            3'd4: if (dat[hits[i]] > val) val = dat[hits[i]];
            default: ;
          endcase
        end
      end
      nextMem[a] = val;
    end
    for (int a = 0; a < NW; a++) refMem[a] = nextMem[a];
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) checkPort(tag, p, expV[p], expD[p], expE[p]);
  endtask

  task automatic readAll(string tag, int a0, int a1, int a2, int a3);
    bit savedRc = readConcurrent;
    readConcurrent = 1'b1;
    clearReq();
    setReq(0, 0, a0, 0); setReq(1, 0, a1, 0); setReq(2, 0, a2, 0); setReq(3, 0, a3, 0);
    stepCycle(tag);
    readConcurrent = savedRc;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements): got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < NW; a++) refMem[a] = 0;
    clearReq();
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    for (int p = 0; p < NP; p++) checkPort("R1", p, 0, 0, 0);
    rstN = 1'b1;
    stepCycle("R1");
    readAll("R1", 0, 1, 2, 7);

    // R11: lone writes, one per port, then read back (R2)
    clearReq();
    setReq(0, 1, 0, 'h0A); setReq(1, 1, 1, 'h1B); setReq(2, 1, 2, 'h2C); setReq(3, 1, 3, 'h3D);
    stepCycle("R11");
    readAll("R2", 3, 2, 1, 0);

    // R12: read and write same word together, old value returned
    clearReq();
    setReq(0, 0, 1, 0); setReq(1, 1, 1, 'h77); setReq(3, 0, 2, 0);
    stepCycle("R12");
    readAll("R12", 1, 1, 0, 0);

    // R3: exclusive read collision next to an unrelated read
    readConcurrent = 1'b0;
    clearReq();
    setReq(0, 0, 0, 0); setReq(1, 0, 0, 0); setReq(2, 0, 3, 0);
    stepCycle("R3");
    clearReq();
    setReq(1, 0, 2, 0); setReq(2, 0, 2, 0); setReq(3, 0, 2, 0);
    stepCycle("R3");

    // R4: shared read of one word by all ports
    readConcurrent = 1'b1;
    clearReq();
    for (int p = 0; p < NP; p++) setReq(p, 0, 2, 0);
    stepCycle("R4");

    // R5: exclusive write collision, other address still commits
    writeConcurrent = 1'b0;
    clearReq();
    setReq(0, 1, 4, 'h11); setReq(1, 1, 4, 'h22); setReq(2, 1, 5, 'h33);
    stepCycle("R5");
    readAll("R5", 4, 5, 4, 5);

    // R6: equal-only policy, match and mismatch in one cycle
    writeConcurrent = 1'b1;
    writePolicy = 3'd0;
    clearReq();
    setReq(1, 1, 6, 'h44); setReq(3, 1, 6, 'h44); setReq(0, 1, 7, 'h01); setReq(2, 1, 7, 'h02);
    stepCycle("R6");
    readAll("R6", 6, 7, 6, 7);

    // R7: keep-lowest policy, then an unused code
    writePolicy = 3'd1;
    clearReq();
    setReq(1, 1, 0, 'h90); setReq(2, 1, 0, 'h10); setReq(3, 1, 0, 'h50);
    stepCycle("R7");
    readAll("R7", 0, 0, 0, 0);
    writePolicy = 3'd6;
    clearReq();
    setReq(2, 1, 1, 'h5A); setReq(3, 1, 1, 'hA5); setReq(0, 1, 2, 'hC3);
    stepCycle("R7");
    readAll("R7", 1, 2, 1, 2);

    // R8: minimum
    writePolicy = 3'd2;
    clearReq();
    setReq(0, 1, 3, 'hF0); setReq(1, 1, 3, 'h08); setReq(3, 1, 3, 'h80);
    stepCycle("R8");
    readAll("R8", 3, 3, 3, 3);

    // R9: wrapping sum
    writePolicy = 3'd3;
    clearReq();
    setReq(0, 1, 4, 'hF0); setReq(2, 1, 4, 'h20); setReq(3, 1, 4, 'h05); setReq(1, 1, 5, 'h09);
    stepCycle("R9");
    readAll("R9", 4, 5, 4, 5);

    // R10: maximum
    writePolicy = 3'd4;
    clearReq();
    setReq(0, 1, 6, 'h7F); setReq(1, 1, 6, 'h80); setReq(2, 1, 6, 'h01);
    stepCycle("R10");
    readAll("R10", 6, 6, 6, 6);

    // R11: idle cycle after activity
    clearReq();
    stepCycle("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule